// File: doc/BRIEF.md
# Over-Current Protection Reaction Timer

This block decides when an over-current condition has lasted long enough to become a protection event. There are two directions, discharge and charge. Each has a sampled over-current flag from an external comparator, a FET enable request from software, a software clear strobe, and a latched trip output. A slow low-power oscillator delivers single-cycle ticks in the fast clock domain. A prescaler groups these ticks into half-millisecond steps. A 6-bit reaction-time code sets how many steps a direction's flag must stay high before that direction trips.

Steps run freely and are not aligned to the onset of the condition. Code n therefore trips after a delay somewhere between n−1 and n steps. Codes 0 and 1 both trip on the first step boundary. Each time a direction's FET switches on, detection in that direction is held off for a short initialization time counted in slow ticks. A trip latches. The matching FET gate is held off until software clears the event. All control pins are plain level or strobe signals, and no pin has a handshake.

Top module: `ocp_reaction_timer`

## Requirements
- R1: After reset both trip outputs and both FET gate outputs are 0, and the reaction-time code is 2.
- R2: A step is one pulse for every STEP_TICKS slow ticks. It comes from a free-running counter, and the last tick of each group is the step. With code n ≥ 1, and with the direction armed and its flag high on every clock, the trip output rises on the clock after the n-th step boundary. With STEP_TICKS=4 and a tick every 3 clocks, this gives a delay of (n−1)·12+1 to n·12 clocks.
- R3: Code 0 behaves exactly as code 1: the trip comes on the first step boundary, 1 to 12 clocks in the setup of R2.
- R4: If the flag drops before the trip, the step count clears. A later episode times its full window again.
- R5: When a direction's gate output rises, the following INIT_TICKS slow ticks must pass before any step counts in that direction. With INIT_TICKS=2, a flag that is already high with code 0 cannot trip earlier than 6 clocks after the enable.
- R6: A trip stays latched while the flag is low. While tripped, that direction's gate output is 0.
- R7: A clear strobe drops the trip on the next clock. The gate output then follows the enable again.
- R8: The two directions are independent. A trip in one direction leaves the other direction's trip and gate untouched.
- R9: A pulse on cfg_we loads cfg_code as the new code, effective from the next clock.
- R10: While a direction's enable is 0, its flag is ignored and it never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per slow oscillator period |
| cfg_we | input | 1 | Load strobe for the reaction-time code |
| cfg_code | input | 6 | New reaction-time code |
| dsg_fet_en | input | 1 | Software request to switch the discharge FET on |
| chg_fet_en | input | 1 | Software request to switch the charge FET on |
| dsg_oc | input | 1 | Sampled discharge over-current flag |
| chg_oc | input | 1 | Sampled charge over-current flag |
| dsg_clear | input | 1 | Clears a latched discharge trip |
| chg_clear | input | 1 | Clears a latched charge trip |
| dsg_trip | output | 1 | Latched discharge protection event |
| chg_trip | output | 1 | Latched charge protection event |
| dsg_fet_on | output | 1 | Discharge FET gate: enable and not tripped |
| chg_fet_on | output | 1 | Charge FET gate: enable and not tripped |

## Verification
Assertions check on every cycle that a trip only begins on a step boundary, with the flag high, the enable high and no initialization pending. They also check that a low flag empties the step count, that trips hold until cleared and drop after a clear, and that code writes land. Only the bench scenarios can show the delay windows themselves. These are the clock ranges per code, the identical behaviour of codes 0 and 1, the longer delay after an enable, and the isolation between directions. The bench measures each of these against bounds taken from the requirements. A behavioural model is also compared on every clock.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    DIR_DSG = 1'b0,
    DIR_CHG = 1'b1
  } ocp_dir_e;

  localparam int NUM_DIR = 2;
endpackage

// File: rtl/ocp_step_prescaler.sv
module ocp_step_prescaler #(
  parameter int STEP_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic step_o
);
  localparam int CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the tick group counter never leaves its range
  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < STEP_TICKS);
endmodule

// File: rtl/ocp_code_reg.sv
module ocp_code_reg #(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_o <= CODE_W'(RESET_CODE);
    else if (we_i) code_o <= wdata_i;
  end

  assert_code_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> code_o == $past(wdata_i));
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel #(
  parameter int CODE_W     = 6,
  parameter int INIT_TICKS = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fet_en_i,
  input  logic              oc_i,
  input  logic              clear_i,
  output logic              trip_o,
  output logic              fet_on_o
);
  localparam int IW = (INIT_TICKS > 0) ? $clog2(INIT_TICKS + 1) : 1;
  localparam logic [IW-1:0] INIT_VAL = IW'(INIT_TICKS);

  logic              trip_q;
  logic              gate_q;
  logic [IW-1:0]     init_q;
  logic [CODE_W-1:0] cnt_q;
  logic              gate_now;
  logic              gate_rise;
  logic              armed;
  logic [CODE_W:0]   limit;
  logic [CODE_W:0]   cnt_next;

  assign gate_now  = fet_en_i && !trip_q;
  assign gate_rise = gate_now && !gate_q;
  assign armed     = gate_now && !gate_rise && (init_q == '0);
  assign limit     = (code_i == '0) ? (CODE_W+1)'(1) : {1'b0, code_i};
  assign cnt_next  = {1'b0, cnt_q} + 1'b1;

  assign trip_o   = trip_q;
  assign fet_on_o = gate_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      init_q <= '0;
    end else begin
      gate_q <= gate_now;
      if (gate_rise)                  init_q <= INIT_VAL;
      else if (tick_i && init_q != '0) init_q <= init_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      trip_q <= 1'b0;
      cnt_q  <= '0;
    end else if (armed && oc_i) begin
      if (step_i) begin
        if (cnt_next >= limit) begin
          trip_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_next[CODE_W-1:0];
        end
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assert_trip_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(step_i && oc_i));

  assert_init_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> ($past(init_q) == '0) && !$past(gate_rise));

  assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_i && !trip_q) |=> cnt_q == '0);

  assert_trip_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clear_i) |=> trip_q);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !trip_q);

  assert_enable_needed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(fet_en_i));
endmodule

// File: rtl/ocp_reaction_timer.sv
module ocp_reaction_timer #(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 2,
  parameter int STEP_TICKS = 64,
  parameter int INIT_TICKS = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              dsg_fet_en,
  input  logic              chg_fet_en,
  input  logic              dsg_oc,
  input  logic              chg_oc,
  input  logic              dsg_clear,
  input  logic              chg_clear,
  output logic              dsg_trip,
  output logic              chg_trip,
  output logic              dsg_fet_on,
  output logic              chg_fet_on
);
  import ocp_pkg::*;

  logic              step;
  logic [CODE_W-1:0] code;
  logic [NUM_DIR-1:0] en_v, oc_v, clr_v, trip_v, on_v;

  assign en_v[DIR_DSG]  = dsg_fet_en;
  assign en_v[DIR_CHG]  = chg_fet_en;
  assign oc_v[DIR_DSG]  = dsg_oc;
  assign oc_v[DIR_CHG]  = chg_oc;
  assign clr_v[DIR_DSG] = dsg_clear;
  assign clr_v[DIR_CHG] = chg_clear;

  assign dsg_trip   = trip_v[DIR_DSG];
  assign chg_trip   = trip_v[DIR_CHG];
  assign dsg_fet_on = on_v[DIR_DSG];
  assign chg_fet_on = on_v[DIR_CHG];

  ocp_step_prescaler #(.STEP_TICKS(STEP_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(osc_tick), .step_o(step)
  );

  ocp_code_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_code), .code_o(code)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    ocp_channel #(.CODE_W(CODE_W), .INIT_TICKS(INIT_TICKS)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(osc_tick), .step_i(step),
      .code_i(code), .fet_en_i(en_v[d]), .oc_i(oc_v[d]), .clear_i(clr_v[d]),
      .trip_o(trip_v[d]), .fet_on_o(on_v[d])
    );
  end

  // R1: no trip in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (trip_v == '0));
endmodule

// File: tb/ocp_reaction_timer_test.sv
module ocp_reaction_timer_test;
  localparam int TPS  = 4;
  localparam int INIT = 2;
  localparam int STEP_CLK = TPS * 3;

  logic clk = 0;
  logic rst_n = 0;
  logic osc_tick = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_code = 0;
  logic dsg_fet_en = 0, chg_fet_en = 0, dsg_oc = 0, chg_oc = 0;
  logic dsg_clear = 0, chg_clear = 0;
  logic dsg_trip, chg_trip, dsg_fet_on, chg_fet_on;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  ocp_reaction_timer #(.CODE_W(6), .RESET_CODE(2), .STEP_TICKS(TPS), .INIT_TICKS(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .dsg_fet_en(dsg_fet_en), .chg_fet_en(chg_fet_en), .dsg_oc(dsg_oc), .chg_oc(chg_oc),
    .dsg_clear(dsg_clear), .chg_clear(chg_clear), .dsg_trip(dsg_trip), .chg_trip(chg_trip),
    .dsg_fet_on(dsg_fet_on), .chg_fet_on(chg_fet_on)
  );

  // slow tick every third clock
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == 2) ? 0 : div + 1;
      osc_tick = (div == 2);
    end
  end

  // behavioural reference
  int m_pre, m_code;
  int m_trip[2], m_cnt[2], m_init[2], m_gprev[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_code = 2;
      for (int d = 0; d < 2; d++) begin
        m_trip[d] = 0; m_cnt[d] = 0; m_init[d] = 0; m_gprev[d] = 0;
      end
    end else begin
      bit stp;
      int lim;
      bit en[2], oc[2], clr[2];
      en[0] = dsg_fet_en; en[1] = chg_fet_en;
      oc[0] = dsg_oc;     oc[1] = chg_oc;
      clr[0] = dsg_clear; clr[1] = chg_clear;
      stp = osc_tick && (m_pre == TPS - 1);
      lim = (m_code == 0) ? 1 : m_code;
      for (int d = 0; d < 2; d++) begin
        bit g, rise, arm;
        g = en[d] && (m_trip[d] == 0);
        rise = g && (m_gprev[d] == 0);
        arm = g && !rise && (m_init[d] == 0);
        if (clr[d]) begin
          m_trip[d] = 0; m_cnt[d] = 0;
        end else if (arm && oc[d]) begin
          if (stp) begin
            if (m_cnt[d] + 1 >= lim) begin m_trip[d] = 1; m_cnt[d] = 0; end
            else m_cnt[d] = m_cnt[d] + 1;
          end
        end else m_cnt[d] = 0;
        if (rise) m_init[d] = INIT;
        else if (osc_tick && m_init[d] > 0) m_init[d] = m_init[d] - 1;
        m_gprev[d] = g;
      end
      if (osc_tick) m_pre = (m_pre == TPS - 1) ? 0 : m_pre + 1;
      if (cfg_we) m_code = int'(cfg_code);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input int act,
                             input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(phase, "model dsg_trip", int'(dsg_trip), m_trip[0]);
      check(phase, "model chg_trip", int'(chg_trip), m_trip[1]);
      check(phase, "model dsg_fet_on", int'(dsg_fet_on), int'(dsg_fet_en && m_trip[0] == 0));
      check(phase, "model chg_fet_on", int'(chg_fet_on), int'(chg_fet_en && m_trip[1] == 0));
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts clocks until the selected trip is seen, up to maxc
  task automatic measure(input bit chg, input int maxc, output int d);
    d = maxc + 1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if ((chg ? chg_trip : dsg_trip) == 1'b1) begin d = i; break; end
    end
  endtask

  task automatic set_code(input int c);
    cfg_code = 6'(c); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_dsg();
    dsg_clear = 1; @(negedge clk); dsg_clear = 0;
  endtask

  initial begin
    int d;
    wait_cyc(4);
    phase = "R1";
    check("R1", "dsg_trip in reset", int'(dsg_trip), 0);
    check("R1", "chg_trip in reset", int'(chg_trip), 0);
    check("R1", "dsg_fet_on in reset", int'(dsg_fet_on), 0);
    rst_n = 1;
    wait_cyc(2);

    // default code 2 window
    phase = "R2";
    dsg_fet_en = 1;
    wait_cyc(20);
    check("R1", "dsg_fet_on after enable", int'(dsg_fet_on), 1);
    dsg_oc = 1;
    measure(0, 40, d);
    check_range("R1", "default code 2 delay", d, STEP_CLK + 1, 2 * STEP_CLK);
    check("R8", "chg_trip untouched", int'(chg_trip), 0);
    dsg_oc = 0;

    // latch
    phase = "R6";
    wait_cyc(30);
    check("R6", "trip held", int'(dsg_trip), 1);
    check("R6", "gate off while tripped", int'(dsg_fet_on), 0);

    phase = "R7";
    clear_dsg();
    check("R7", "trip cleared", int'(dsg_trip), 0);
    check("R7", "gate back on", int'(dsg_fet_on), 1);
    wait_cyc(20);

    // code 0 and 1 alike
    phase = "R3";
    set_code(0);
    dsg_oc = 1;
    measure(0, 30, d);
    check_range("R3", "code 0 delay", d, 1, STEP_CLK);
    dsg_oc = 0; clear_dsg(); wait_cyc(20);
    set_code(1);
    dsg_oc = 1;
    measure(0, 30, d);
    check_range("R3", "code 1 delay", d, 1, STEP_CLK);
    dsg_oc = 0; clear_dsg(); wait_cyc(20);

    // larger codes
    phase = "R9";
    set_code(5);
    dsg_oc = 1;
    measure(0, 80, d);
    check_range("R9", "code 5 delay", d, 4 * STEP_CLK + 1, 5 * STEP_CLK);
    dsg_oc = 0; clear_dsg(); wait_cyc(20);
    set_code(63);
    dsg_oc = 1;
    measure(0, 800, d);
    check_range("R2", "code 63 delay", d, 62 * STEP_CLK + 1, 63 * STEP_CLK);
    dsg_oc = 0; clear_dsg(); wait_cyc(20);

    // restart on drop
    phase = "R4";
    set_code(5);
    dsg_oc = 1;
    wait_cyc(40);
    check("R4", "no trip before drop", int'(dsg_trip), 0);
    dsg_oc = 0;
    wait_cyc(2);
    dsg_oc = 1;
    measure(0, 80, d);
    check_range("R4", "full window after restart", d, 4 * STEP_CLK + 1, 5 * STEP_CLK);
    dsg_oc = 0; clear_dsg(); wait_cyc(20);

    // init hold-off on charge side
    phase = "R5";
    set_code(0);
    chg_oc = 1;
    chg_fet_en = 1;
    measure(1, 40, d);
    check_range("R5", "delay after enable", d, 6, 19);
    check("R8", "dsg unaffected by chg trip", int'(dsg_trip), 0);
    check("R8", "dsg gate unaffected", int'(dsg_fet_on), 1);
    check("R6", "chg gate off", int'(chg_fet_on), 0);
    chg_oc = 0;
    chg_clear = 1; @(negedge clk); chg_clear = 0;
    check("R7", "chg cleared", int'(chg_trip), 0);
    wait_cyc(10);

    // enable low ignores flag
    phase = "R10";
    dsg_fet_en = 0;
    dsg_oc = 1;
    wait_cyc(100);
    check("R10", "no trip while disabled", int'(dsg_trip), 0);
    check("R10", "gate off while disabled", int'(dsg_fet_on), 0);
    dsg_oc = 0;
    wait_cyc(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule